// File: doc/BRIEF.md
# Interrupt Vector Request and In-Service Tracker

This block keeps, for one local interrupt controller, two 256-entry bit sets: the vectors whose interrupts are requested and waiting, and the vectors currently being serviced. Each set is stored as eight 32-bit words. Vector v is bit v%32 of word v/32. Separate set and clear commands act on each set. An acknowledge command moves a vector from requested to in service. An end-of-interrupt command retires the highest vector in service. The highest set vector of each set is reported continuously from a register, so downstream priority logic sees a stable value.

Next to the two bit sets sit five special pending slots. They are system-management, non-maskable, external, init and startup. Each has its own pending flag and its own latched 8-bit vector, and none of them ever enters the request set. A registered summary flag tells the core that an urgent special interrupt is pending. It covers every slot except the external one.

The block has no states. All behaviour is a set of registered word updates plus two priority searches. Priority-class comparison, bus access and message delivery belong to neighbouring blocks.

Top module: `irq_vec_tracker`

## Requirements
- R1: Any of the 256 vectors, including 0, 31, 32 and 255, can be set in the request set independently. Once set, it is reported as the highest request when no larger vector is set.
- R2: `req_top` equals the largest set vector of the request set, and 0 when the set is empty.
- R3: `svc_top` equals the largest set vector of the in-service set, and 0 when the set is empty.
- R4: A command sampled on rising edge k changes the set at edge k. `req_top` and `svc_top` reflect the change from edge k+1 onward and still show the old value between edges k and k+1.
- R5: A clear command removes the addressed bit. Clearing a bit that is not set changes nothing.
- R6: When a set and a clear of the same bit of one set arrive in the same cycle, the bit ends up set.
- R7: An acknowledge of vector v clears request bit v and sets in-service bit v in the same cycle.
- R8: An end-of-interrupt clears the highest set in-service bit as it stands in that cycle. On an empty in-service set it has no effect.
- R9: Special slot i is selected by bit i of `spec_set`/`spec_clr`. The bit index per slot is 0 system-management, 1 non-maskable, 2 external, 3 init, 4 startup. Setting a slot raises its flag and latches `spec_vec_in` into its 8-bit vector field, which is `spec_vec[8*i +: 8]`. Clearing a slot drops the flag and keeps the vector. A set wins over a clear in the same cycle.
- R10: Special slot commands never change the request set or the in-service set.
- R11: `urgent_pend` is 1 exactly when any of slots 0, 1, 3 or 4 is pending. Slot 2 is excluded. It updates on the same edge as the flags.
- R12: Reset clears both sets, both highest-vector outputs, all special flags and vectors, and `urgent_pend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set_en | input | 1 | Set a request bit |
| req_set_vec | input | 8 | Vector to set in the request set |
| req_clr_en | input | 1 | Clear a request bit |
| req_clr_vec | input | 8 | Vector to clear in the request set |
| svc_set_en | input | 1 | Set an in-service bit |
| svc_set_vec | input | 8 | Vector to set in the in-service set |
| svc_clr_en | input | 1 | Clear an in-service bit |
| svc_clr_vec | input | 8 | Vector to clear in the in-service set |
| ack_en | input | 1 | Acknowledge: move a vector from request to in service |
| ack_vec | input | 8 | Vector acknowledged |
| eoi_en | input | 1 | End of interrupt: retire the highest in-service vector |
| spec_set | input | 5 | Per-slot set strobes |
| spec_clr | input | 5 | Per-slot clear strobes |
| spec_vec_in | input | 8 | Vector latched into every slot set this cycle |
| req_top | output | 8 | Highest requested vector, registered |
| svc_top | output | 8 | Highest in-service vector, registered |
| spec_pend | output | 5 | Special slot pending flags |
| spec_vec | output | 40 | Latched vectors, slot i in bits 8*i+7..8*i |
| urgent_pend | output | 1 | Any special slot other than external pending |

## Verification
The bench targets the word edges of the search: vectors 0, 31, 32 and 255. A search that scans words in the wrong order, or drops word 7, would report a lower vector there. It also drives same-cycle collisions. A set meeting a clear on one bit, and an acknowledge meeting a request set, would leave the bit cleared if the priority were reversed. An end-of-interrupt arriving right after an in-service change would retire a stale vector if the target were taken from the registered output. Special slot commands are interleaved with request traffic. This catches a slot leaking into the request set, and a summary flag that wrongly includes the external slot.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    parameter int NUM_SPEC = 5;

    typedef enum logic [2:0] {
        SLOT_SYSMGMT = 3'd0,
        SLOT_NMI     = 3'd1,
        SLOT_EXT     = 3'd2,
        SLOT_INIT    = 3'd3,
        SLOT_START   = 3'd4
    } slot_e;

    // Slots that feed the urgent summary: all except the external slot.
    localparam logic [NUM_SPEC-1:0] URGENT_MASK =
        ~(NUM_SPEC'(1) << SLOT_EXT);

endpackage

// File: rtl/ivt_bit_array.sv
module ivt_bit_array #(
    parameter int NUM_BITS = 256,
    parameter int WORD_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_BITS-1:0] set_mask,
    input  logic [NUM_BITS-1:0] clr_mask,
    output logic [NUM_BITS-1:0] bits_o
);

    localparam int NUM_WORDS = NUM_BITS / WORD_W;

    logic [WORD_W-1:0] word_q [NUM_WORDS];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[w] <= '0;
            end else begin
                word_q[w] <= (word_q[w] & ~clr_mask[w*WORD_W +: WORD_W])
                           | set_mask[w*WORD_W +: WORD_W];
            end
        end
        assign bits_o[w*WORD_W +: WORD_W] = word_q[w];
    end

    // R6: a requested set always lands, even against a clear.
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0) |=> ((bits_o & $past(set_mask)) == $past(set_mask)));

    // R5: a clear that is not overridden leaves the bit at zero.
    a_r5_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_mask & ~set_mask) != '0) |=>
            ((bits_o & $past(clr_mask & ~set_mask)) == '0));

endmodule

// File: rtl/ivt_msb_find.sv
module ivt_msb_find #(
    parameter int NUM_BITS = 256,
    parameter int WORD_W   = 32,
    parameter int IDX_W    = $clog2(NUM_BITS)
) (
    input  logic [NUM_BITS-1:0] bits_i,
    output logic [IDX_W-1:0]    top_o
);

    localparam int NUM_WORDS = NUM_BITS / WORD_W;
    localparam int WIDX_W    = $clog2(WORD_W);

    logic [WIDX_W-1:0]    word_msb [NUM_WORDS];
    logic [NUM_WORDS-1:0] word_nz;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        always_comb begin
            word_msb[w] = '0;
            for (int b = 0; b < WORD_W; b++) begin
                if (bits_i[w*WORD_W + b]) word_msb[w] = WIDX_W'(b);
            end
        end
        assign word_nz[w] = |bits_i[w*WORD_W +: WORD_W];
    end

    // Highest non-zero word wins: ascending scan, last hit kept.
    always_comb begin
        top_o = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word_nz[w]) top_o = IDX_W'(w * WORD_W) + IDX_W'(word_msb[w]);
        end
    end

endmodule

// File: rtl/ivt_special_slots.sv
module ivt_special_slots
    import ivt_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SPEC-1:0]       set_i,
    input  logic [NUM_SPEC-1:0]       clr_i,
    input  logic [VEC_W-1:0]          vec_i,
    output logic [NUM_SPEC-1:0]       pend_o,
    output logic [NUM_SPEC*VEC_W-1:0] vec_o,
    output logic                      urgent_o
);

    logic [NUM_SPEC-1:0] pend_q;
    logic [NUM_SPEC-1:0] pend_next;
    logic                urgent_q;

    assign pend_next = (pend_q & ~clr_i) | set_i;

    for (genvar i = 0; i < NUM_SPEC; i++) begin : g_slot
        logic [VEC_W-1:0] vec_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vec_q <= '0;
            end else if (set_i[i]) begin
                vec_q <= vec_i;
            end
        end
        assign vec_o[i*VEC_W +: VEC_W] = vec_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= '0;
            urgent_q <= 1'b0;
        end else begin
            pend_q   <= pend_next;
            urgent_q <= |(pend_next & URGENT_MASK);
        end
    end

    assign pend_o   = pend_q;
    assign urgent_o = urgent_q;

    // R11: the summary register agrees with the flag register.
    a_r11_summary: assert property (@(posedge clk) disable iff (!rst_n)
        urgent_q == |(pend_q & URGENT_MASK));

    // R9: a set strobe raises the flag and captures the vector.
    a_r9_slot_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/irq_vec_tracker.sv
module irq_vec_tracker
    import ivt_pkg::*;
#(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_set_en,
    input  logic [7:0]              req_set_vec,
    input  logic                    req_clr_en,
    input  logic [7:0]              req_clr_vec,
    input  logic                    svc_set_en,
    input  logic [7:0]              svc_set_vec,
    input  logic                    svc_clr_en,
    input  logic [7:0]              svc_clr_vec,
    input  logic                    ack_en,
    input  logic [7:0]              ack_vec,
    input  logic                    eoi_en,
    input  logic [4:0]              spec_set,
    input  logic [4:0]              spec_clr,
    input  logic [7:0]              spec_vec_in,
    output logic [7:0]              req_top,
    output logic [7:0]              svc_top,
    output logic [4:0]              spec_pend,
    output logic [39:0]             spec_vec,
    output logic                    urgent_pend
);

    localparam int VEC_W = $clog2(NUM_VEC);

    logic [NUM_VEC-1:0] req_set_mask, req_clr_mask;
    logic [NUM_VEC-1:0] svc_set_mask, svc_clr_mask;
    logic [NUM_VEC-1:0] req_arr, svc_arr;
    logic [VEC_W-1:0]   req_msb_now, svc_msb_now;
    logic [VEC_W-1:0]   req_top_q, svc_top_q;

    // Command decode; the end-of-interrupt target comes from the live search.
    always_comb begin
        req_set_mask = '0;
        req_clr_mask = '0;
        svc_set_mask = '0;
        svc_clr_mask = '0;
        if (req_set_en) req_set_mask[req_set_vec] = 1'b1;
        if (req_clr_en) req_clr_mask[req_clr_vec] = 1'b1;
        if (ack_en)     req_clr_mask[ack_vec]     = 1'b1;
        if (svc_set_en) svc_set_mask[svc_set_vec] = 1'b1;
        if (ack_en)     svc_set_mask[ack_vec]     = 1'b1;
        if (svc_clr_en) svc_clr_mask[svc_clr_vec] = 1'b1;
        if (eoi_en && (svc_arr != '0)) svc_clr_mask[svc_msb_now] = 1'b1;
    end

    ivt_bit_array #(.NUM_BITS(NUM_VEC), .WORD_W(WORD_W)) u_req_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (req_set_mask),
        .clr_mask (req_clr_mask),
        .bits_o   (req_arr)
    );

    ivt_bit_array #(.NUM_BITS(NUM_VEC), .WORD_W(WORD_W)) u_svc_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (svc_set_mask),
        .clr_mask (svc_clr_mask),
        .bits_o   (svc_arr)
    );

    ivt_msb_find #(.NUM_BITS(NUM_VEC), .WORD_W(WORD_W), .IDX_W(VEC_W)) u_req_find (
        .bits_i (req_arr),
        .top_o  (req_msb_now)
    );

    ivt_msb_find #(.NUM_BITS(NUM_VEC), .WORD_W(WORD_W), .IDX_W(VEC_W)) u_svc_find (
        .bits_i (svc_arr),
        .top_o  (svc_msb_now)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_top_q <= '0;
            svc_top_q <= '0;
        end else begin
            req_top_q <= req_msb_now;
            svc_top_q <= svc_msb_now;
        end
    end

    assign req_top = req_top_q;
    assign svc_top = svc_top_q;

    ivt_special_slots #(.VEC_W(VEC_W)) u_spec (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (spec_set),
        .clr_i    (spec_clr),
        .vec_i    (spec_vec_in),
        .pend_o   (spec_pend),
        .vec_o    (spec_vec),
        .urgent_o (urgent_pend)
    );

    // Delayed copies of the sets, for checking the registered search results.
    logic [NUM_VEC-1:0] req_arr_d, svc_arr_d;
    always_ff @(posedge clk) begin
        req_arr_d <= req_arr;
        svc_arr_d <= svc_arr;
    end

    // R2: registered request top is the MSB of the set one cycle earlier.
    a_r2_req_top_is_msb: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
            ((req_arr_d >> req_top_q) == NUM_VEC'(req_arr_d != '0)));

    // R3: same for the in-service top.
    a_r3_svc_top_is_msb: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
            ((svc_arr_d >> svc_top_q) == NUM_VEC'(svc_arr_d != '0)));

    // R7: acknowledge moves the vector between the sets.
    a_r7_ack_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_en && !(req_set_en && req_set_vec == ack_vec)) |=>
            (!req_arr[$past(ack_vec)] && svc_arr[$past(ack_vec)]));

    // R8: end-of-interrupt retires the live highest in-service vector.
    a_r8_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_en && !(svc_set_en && svc_set_vec == svc_msb_now)
                && !(ack_en && ack_vec == svc_msb_now)) |=>
            !svc_arr[$past(svc_msb_now)]);

endmodule

// File: tb/irq_vec_tracker_tb.sv
module irq_vec_tracker_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_set_en, req_clr_en, svc_set_en, svc_clr_en, ack_en, eoi_en;
    logic [7:0]  req_set_vec, req_clr_vec, svc_set_vec, svc_clr_vec, ack_vec;
    logic [4:0]  spec_set, spec_clr;
    logic [7:0]  spec_vec_in;
    logic [7:0]  req_top, svc_top;
    logic [4:0]  spec_pend;
    logic [39:0] spec_vec;
    logic        urgent_pend;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    logic [255:0] m_req, m_svc;
    logic [4:0]   m_pend;
    logic [7:0]   m_vec [5];

    always #10 clk = ~clk;   // 50 MHz

    irq_vec_tracker u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_set_en(req_set_en), .req_set_vec(req_set_vec),
        .req_clr_en(req_clr_en), .req_clr_vec(req_clr_vec),
        .svc_set_en(svc_set_en), .svc_set_vec(svc_set_vec),
        .svc_clr_en(svc_clr_en), .svc_clr_vec(svc_clr_vec),
        .ack_en(ack_en), .ack_vec(ack_vec), .eoi_en(eoi_en),
        .spec_set(spec_set), .spec_clr(spec_clr), .spec_vec_in(spec_vec_in),
        .req_top(req_top), .svc_top(svc_top), .spec_pend(spec_pend),
        .spec_vec(spec_vec), .urgent_pend(urgent_pend)
    );

    function automatic logic [7:0] msb_of(input logic [255:0] a);
        logic [7:0] r = 8'd0;
        for (int i = 0; i < 256; i++) if (a[i]) r = 8'(i);
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        req_set_en = 0; req_clr_en = 0; svc_set_en = 0; svc_clr_en = 0;
        ack_en = 0; eoi_en = 0; spec_set = '0; spec_clr = '0;
        req_set_vec = 0; req_clr_vec = 0; svc_set_vec = 0; svc_clr_vec = 0;
        ack_vec = 0; spec_vec_in = 0;
    endtask

    task automatic model_reset();
        m_req = '0; m_svc = '0; m_pend = '0;
        for (int i = 0; i < 5; i++) m_vec[i] = 8'd0;
    endtask

    task automatic check_all(input string when);
        chk(req_top == msb_of(m_req), {"R2 req_top ", when}, req_top, msb_of(m_req));
        chk(svc_top == msb_of(m_svc), {"R3 svc_top ", when}, svc_top, msb_of(m_svc));
        chk(spec_pend == m_pend, {"R9 spec_pend ", when}, spec_pend, m_pend);
        for (int i = 0; i < 5; i++)
            chk(spec_vec[8*i +: 8] == m_vec[i], {"R9 spec_vec ", when}, spec_vec[8*i +: 8], m_vec[i]);
        chk(urgent_pend == |(m_pend & 5'b11011), {"R11 urgent ", when},
            urgent_pend, |(m_pend & 5'b11011));
    endtask

    // Inputs are already driven (at a negedge); commit one cycle and check.
    task automatic commit();
        logic [255:0] one = 256'd1;
        logic [255:0] rs, rc, ss, sc;
        logic [7:0]   old_rt, old_st, eoi_t;
        old_rt = msb_of(m_req);
        old_st = msb_of(m_svc);
        eoi_t  = msb_of(m_svc);
        rs = req_set_en ? (one << req_set_vec) : '0;
        rc = (req_clr_en ? (one << req_clr_vec) : '0) | (ack_en ? (one << ack_vec) : '0);
        ss = (svc_set_en ? (one << svc_set_vec) : '0) | (ack_en ? (one << ack_vec) : '0);
        sc = (svc_clr_en ? (one << svc_clr_vec) : '0)
           | ((eoi_en && m_svc != '0) ? (one << eoi_t) : '0);
        m_req  = (m_req & ~rc) | rs;
        m_svc  = (m_svc & ~sc) | ss;
        for (int i = 0; i < 5; i++) if (spec_set[i]) m_vec[i] = spec_vec_in;
        m_pend = (m_pend & ~spec_clr) | spec_set;
        @(posedge clk);
        @(negedge clk);
        idle();
        // R4: tops still show the previous contents here.
        chk(req_top == old_rt, "R4 req_top early", req_top, old_rt);
        chk(svc_top == old_st, "R4 svc_top early", svc_top, old_st);
        @(posedge clk);
        @(negedge clk);
        check_all("after");
    endtask

    task automatic do_reset();
        rst_n = 0;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        idle();
        do_reset();
        check_all("R12 reset");

        // R1: word-boundary vectors
        req_set_en = 1; req_set_vec = 8'd0;   commit();
        chk(req_top == 8'd0, "R1 vec0", req_top, 0);
        req_set_en = 1; req_set_vec = 8'd31;  commit();
        chk(req_top == 8'd31, "R1 vec31", req_top, 31);
        req_set_en = 1; req_set_vec = 8'd32;  commit();
        chk(req_top == 8'd32, "R1 vec32", req_top, 32);
        req_set_en = 1; req_set_vec = 8'd255; commit();
        chk(req_top == 8'd255, "R1 vec255", req_top, 255);

        // R5: clear top, clear an unset bit
        req_clr_en = 1; req_clr_vec = 8'd255; commit();
        chk(req_top == 8'd32, "R5 clear top", req_top, 32);
        req_clr_en = 1; req_clr_vec = 8'd100; commit();
        chk(req_top == 8'd32, "R5 clear unset", req_top, 32);

        // R6: set and clear same bit
        req_set_en = 1; req_set_vec = 8'd200; req_clr_en = 1; req_clr_vec = 8'd200; commit();
        chk(req_top == 8'd200, "R6 set wins req", req_top, 200);
        svc_set_en = 1; svc_set_vec = 8'd77; svc_clr_en = 1; svc_clr_vec = 8'd77; commit();
        chk(svc_top == 8'd77, "R6 set wins svc", svc_top, 77);

        // R7: acknowledge 200
        ack_en = 1; ack_vec = 8'd200; commit();
        chk(req_top == 8'd32, "R7 ack req cleared", req_top, 32);
        chk(svc_top == 8'd200, "R7 ack svc set", svc_top, 200);

        // R8: eoi right after change retires live top
        svc_set_en = 1; svc_set_vec = 8'd210; commit();
        eoi_en = 1; commit();
        chk(svc_top == 8'd200, "R8 eoi top", svc_top, 200);
        eoi_en = 1; commit();
        eoi_en = 1; commit();
        chk(svc_top == 8'd0, "R8 eoi drain", svc_top, 0);
        eoi_en = 1; commit();
        chk(svc_top == 8'd0, "R8 eoi empty", svc_top, 0);

        // R9/R10/R11: special slots
        spec_set = 5'b00100; spec_vec_in = 8'h21; commit();
        chk(urgent_pend == 1'b0, "R11 ext excluded", urgent_pend, 0);
        chk(req_top == 8'd32, "R10 req untouched", req_top, 32);
        spec_set = 5'b00010; spec_vec_in = 8'h02; commit();
        chk(urgent_pend == 1'b1, "R11 nmi urgent", urgent_pend, 1);
        spec_set = 5'b00010; spec_clr = 5'b00010; spec_vec_in = 8'h09; commit();
        chk(spec_pend[1] && spec_vec[15:8] == 8'h09, "R9 set wins slot", spec_vec[15:8], 9);
        spec_clr = 5'b00010; commit();
        chk(spec_vec[15:8] == 8'h09, "R9 vec kept", spec_vec[15:8], 9);
        chk(svc_top == 8'd0 && req_top == 8'd32, "R10 sets untouched", req_top, 32);

        // Random phase
        for (int it = 0; it < 400; it++) begin
            req_set_en  = ($urandom % 3) == 0; req_set_vec = 8'($urandom);
            req_clr_en  = ($urandom % 4) == 0; req_clr_vec = ($urandom % 2) ? req_set_vec : 8'($urandom);
            svc_set_en  = ($urandom % 4) == 0; svc_set_vec = 8'($urandom);
            svc_clr_en  = ($urandom % 6) == 0; svc_clr_vec = 8'($urandom);
            ack_en      = ($urandom % 4) == 0; ack_vec     = ($urandom % 2) ? msb_of(m_req) : 8'($urandom);
            eoi_en      = ($urandom % 4) == 0;
            spec_set    = (($urandom % 3) == 0) ? 5'($urandom) : 5'd0;
            spec_clr    = (($urandom % 3) == 0) ? 5'($urandom) : 5'd0;
            spec_vec_in = 8'($urandom);
            commit();
        end

        // R12: reset after traffic
        req_set_en = 1; req_set_vec = 8'd150; spec_set = 5'b11111; spec_vec_in = 8'h55; commit();
        do_reset();
        check_all("R12 reset2");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule